// File: doc/BRIEF.md
# Edge-Triggered Prioritized Interrupt Controller

This block collects one nonmaskable interrupt line and a set of external interrupt lines (four by default) and turns them into a single interrupt request with a source number and a vector address. The lines are sampled only while the clock-phase indication is high. A low-to-high change between two sampled values latches a pending bit. A line that stays high raises one request only. A short low dip that is sampled, followed by a return high, counts as a new edge and raises a new request.

A fixed-priority encoder picks the request to present. The nonmaskable source always wins and bypasses every enable. The external sources compete by index, and a lower index wins. Each external source takes part only when the global enable and its own mask bit are both set. Its pending bit stays latched while it is masked.

Software reaches the pending bits through two write strobes. A port-mode write sets the pending bits named in the data word. A pending-clear write clears them. An acknowledge pulse clears the bit of the source currently presented.

Top module: `irq_ctrl_top`

## Requirements
- R1: Interrupt lines are sampled only on clock edges where `phase2` is 1. A line that rises and falls while `phase2` is 0 leaves every pending bit unchanged.
- R2: When a sampled line goes from 0 to 1, its pending bit is set at that same clock edge. A line held at 1 afterwards raises no further request once it has been acknowledged.
- R3: If a line held high is sampled low for one phase-2 edge and then sampled high again, the pending bit is set again.
- R4: A pending nonmaskable request drives `irq`=1, `src_id`=0 and `vector`=0xFF203E. This holds whatever the values of `glob_en`, `mask` and the external pending bits.
- R5: External source i reaches the encoder only when `glob_en`=1 and `mask[i]`=1. Its pending bit stays set while it is masked, and the request appears once both enables are set.
- R6: Among enabled external sources, the lowest index wins. The block then outputs `src_id`=i+1 and `vector`=0xFF2010+2*i.
- R7: `ack`=1 clears the pending bit of the presented source at that clock edge. A new rising edge on the same source at that same edge keeps the bit set.
- R8: `mode_we`=1 sets the external pending bits where `wr_data` is 1. `clr_we`=1 clears them.
- R9: When `mode_we` and `clr_we` are both 1, the clear wins for every bit set in `wr_data`.
- R10: After reset, and whenever no request is presented, `irq`=0, `src_id`=0 and `vector`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase2 | input | 1 | Sampling phase indication (1 = sample the lines) |
| nmi_line | input | 1 | Nonmaskable interrupt line |
| ext_line | input | N_EXT | External interrupt lines |
| glob_en | input | 1 | Global enable for external sources |
| mask | input | N_EXT | Per-source enable for external sources |
| mode_we | input | 1 | Port-mode write strobe; sets the pending bits selected by `wr_data` |
| clr_we | input | 1 | Pending-clear write strobe; clears the pending bits selected by `wr_data` |
| wr_data | input | N_EXT | Write data, one bit per external source |
| ack | input | 1 | Acknowledge of the presented source |
| irq | output | 1 | Interrupt request |
| src_id | output | SRC_W | Presented source: 0 = nonmaskable, i+1 = external i |
| vector | output | 24 | Vector address of the presented source |

## Verification
A pending bit that is wrongly held or lost becomes visible at `irq`, `src_id` and `vector` as soon as that source is the highest enabled one. The bench makes this happen by masking, unmasking and acknowledging in sequence, so a stuck bit shows up within one or two cycles as a wrong source or a request that will not clear. A wrong sampler state, such as sampling in the wrong phase or keeping a stale previous value, shows at the next phase-2 edge: a request appears or goes missing in that very cycle. Priority or vector errors show in the same cycle that two sources are pending together.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int VEC_W = 24;
    localparam logic [VEC_W-1:0] NMI_VECTOR = 24'hFF203E;
    localparam logic [VEC_W-1:0] EXT_VECTOR_BASE = 24'hFF2010;

    // Vector slot of external source idx: base plus two bytes per index.
    function automatic logic [VEC_W-1:0] ext_vector(input int idx);
        return EXT_VECTOR_BASE + VEC_W'(2 * idx);
    endfunction

    // Which request the encoder is presenting.
    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_NMI  = 2'd1,
        GRANT_EXT  = 2'd2
    } grant_kind_e;

endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         phase2,
    input  logic [W-1:0] line_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] sampled_q;

    // The held sample changes only on phase-2 edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            sampled_q <= '0;
        end else if (phase2) begin
            sampled_q <= line_in;
        end
    end

    // A rise is a new sample of 1 over a held sample of 0.
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_rise
            assign rise[g] = phase2 & line_in[g] & ~sampled_q[g];
        end
    endgenerate
endmodule

// File: rtl/irq_pending_regs.sv
module irq_pending_regs #(
    parameter int N_EXT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nmi_rise,
    input  logic [N_EXT-1:0] ext_rise,
    input  logic             mode_we,
    input  logic             clr_we,
    input  logic [N_EXT-1:0] wr_data,
    input  logic             ack_nmi,
    input  logic [N_EXT-1:0] ack_ext,
    output logic             nmi_pend,
    output logic [N_EXT-1:0] ext_pend
);
    logic [N_EXT-1:0] set_sw;
    logic [N_EXT-1:0] clr_sw;
    logic [N_EXT-1:0] ext_next;
    logic             nmi_next;

    assign set_sw = mode_we ? wr_data : '0;
    assign clr_sw = clr_we  ? wr_data : '0;

    // Clear beats the software set; a hardware edge beats every clear.
    always_comb begin
        ext_next = ((ext_pend | set_sw) & ~clr_sw & ~ack_ext) | ext_rise;
        nmi_next = (nmi_pend & ~ack_nmi) | nmi_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend <= '0;
            nmi_pend <= 1'b0;
        end else begin
            ext_pend <= ext_next;
            nmi_pend <= nmi_next;
        end
    end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int SRC_W = 3
) (
    input  logic             nmi_pend,
    input  logic [N_EXT-1:0] ext_pend,
    input  logic             glob_en,
    input  logic [N_EXT-1:0] mask,
    output logic             irq,
    output logic [SRC_W-1:0] src_id,
    output logic [VEC_W-1:0] vector,
    output logic             grant_nmi,
    output logic [N_EXT-1:0] grant_ext
);
    logic [N_EXT-1:0] eligible;
    grant_kind_e      kind;

    assign eligible = glob_en ? (ext_pend & mask) : '0;

    always_comb begin
        kind      = GRANT_NONE;
        src_id    = '0;
        vector    = '0;
        grant_ext = '0;
        if (nmi_pend) begin
            kind   = GRANT_NMI;
            vector = NMI_VECTOR;
        end else begin
            for (int i = 0; i < N_EXT; i++) begin
                if (eligible[i] && kind == GRANT_NONE) begin
                    kind         = GRANT_EXT;
                    src_id       = SRC_W'(i + 1);
                    vector       = ext_vector(i);
                    grant_ext[i] = 1'b1;
                end
            end
        end
    end

    assign irq       = (kind != GRANT_NONE);
    assign grant_nmi = (kind == GRANT_NMI);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int SRC_W = $clog2(N_EXT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase2,
    input  logic             nmi_line,
    input  logic [N_EXT-1:0] ext_line,
    input  logic             glob_en,
    input  logic [N_EXT-1:0] mask,
    input  logic             mode_we,
    input  logic             clr_we,
    input  logic [N_EXT-1:0] wr_data,
    input  logic             ack,
    output logic             irq,
    output logic [SRC_W-1:0] src_id,
    output logic [23:0]      vector
);
    localparam int LINES = N_EXT + 1;

    logic [LINES-1:0] rise_all;
    logic             nmi_pend;
    logic [N_EXT-1:0] ext_pend;
    logic             grant_nmi;
    logic [N_EXT-1:0] grant_ext;

    irq_edge_sampler #(.W(LINES)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .phase2  (phase2),
        .line_in ({ext_line, nmi_line}),
        .rise    (rise_all)
    );

    irq_pending_regs #(.N_EXT(N_EXT)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .nmi_rise (rise_all[0]),
        .ext_rise (rise_all[LINES-1:1]),
        .mode_we  (mode_we),
        .clr_we   (clr_we),
        .wr_data  (wr_data),
        .ack_nmi  (ack & grant_nmi),
        .ack_ext  (ack ? grant_ext : '0),
        .nmi_pend (nmi_pend),
        .ext_pend (ext_pend)
    );

    irq_prio_encoder #(.N_EXT(N_EXT), .SRC_W(SRC_W)) u_enc (
        .nmi_pend  (nmi_pend),
        .ext_pend  (ext_pend),
        .glob_en   (glob_en),
        .mask      (mask),
        .irq       (irq),
        .src_id    (src_id),
        .vector    (vector),
        .grant_nmi (grant_nmi),
        .grant_ext (grant_ext)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int SRC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             phase2,
    input logic             ack,
    input logic             mode_we,
    input logic             clr_we,
    input logic [N_EXT-1:0] wr_data,
    input logic             glob_en,
    input logic             irq,
    input logic [SRC_W-1:0] src_id,
    input logic [23:0]      vector,
    input logic             nmi_pend,
    input logic [N_EXT-1:0] ext_pend
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (src_id == '0 && vector == '0)); // R10

    AST_NMI_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
        nmi_pend |-> (irq && src_id == '0 && vector == NMI_VECTOR)); // R4

    AST_EXT_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (irq && src_id != '0) |-> glob_en); // R5

    AST_OFFPHASE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!phase2 && !ack && !mode_we && !clr_we) |=>
        (ext_pend == $past(ext_pend) && nmi_pend == $past(nmi_pend))); // R1

    AST_CLEAR_BEATS_SET: assert property (@(posedge clk) disable iff (rst)
        (mode_we && clr_we && !phase2) |=> ((ext_pend & $past(wr_data)) == '0)); // R9

    genvar g;
    generate
        for (g = 0; g < N_EXT; g++) begin : g_ack
            AST_ACK_DROPS_BIT: assert property (@(posedge clk) disable iff (rst)
                (ack && irq && src_id == SRC_W'(g + 1) && !phase2 && !mode_we)
                |=> !ext_pend[g]); // R7
        end
    endgenerate
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.N_EXT(N_EXT), .SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phase2   (phase2),
    .ack      (ack),
    .mode_we  (mode_we),
    .clr_we   (clr_we),
    .wr_data  (wr_data),
    .glob_en  (glob_en),
    .irq      (irq),
    .src_id   (src_id),
    .vector   (vector),
    .nmi_pend (nmi_pend),
    .ext_pend (ext_pend)
);

// File: tb/sim_irq_ctrl_top.sv
module sim_irq_ctrl_top;
    localparam int N_EXT = 4;
    localparam int SRC_W = 3;
    localparam logic [23:0] NMI_V = 24'hFF203E;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             phase2 = 1'b0;
    logic             nmi_line = 1'b0;
    logic [N_EXT-1:0] ext_line = '0;
    logic             glob_en = 1'b0;
    logic [N_EXT-1:0] mask = '0;
    logic             mode_we = 1'b0;
    logic             clr_we = 1'b0;
    logic [N_EXT-1:0] wr_data = '0;
    logic             ack = 1'b0;
    logic             irq;
    logic [SRC_W-1:0] src_id;
    logic [23:0]      vector;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_ctrl_top #(.N_EXT(N_EXT)) u0 (
        .clk(clk), .rst(rst), .phase2(phase2), .nmi_line(nmi_line),
        .ext_line(ext_line), .glob_en(glob_en), .mask(mask),
        .mode_we(mode_we), .clr_we(clr_we), .wr_data(wr_data), .ack(ack),
        .irq(irq), .src_id(src_id), .vector(vector)
    );

    function automatic logic [23:0] ev(input int i);
        return 24'hFF2010 + 24'(2 * i);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic e_irq,
                              input logic [SRC_W-1:0] e_src, input logic [23:0] e_vec);
        n_chk++;
        if (irq !== e_irq || src_id !== e_src || vector !== e_vec) begin
            n_bad++;
            $display("FAIL %s: got irq=%0b src=%0d vec=%h, expected irq=%0b src=%0d vec=%h",
                     tag, irq, src_id, vector, e_irq, e_src, e_vec);
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R10 reset state", 1'b0, 3'd0, 24'h0);
    endtask

    task automatic t_phase_gate();
        phase2 = 1'b0;
        ext_line = 4'b0001;
        step();
        ext_line = 4'b0000;
        step();
        expect_out("R1 off-phase pulse ignored", 1'b0, 3'd0, 24'h0);
        phase2 = 1'b1;
        step();
        expect_out("R1 no late detection", 1'b0, 3'd0, 24'h0);
    endtask

    task automatic t_single_edge();
        ext_line[2] = 1'b1;
        step();
        expect_out("R2 rise sets pending", 1'b1, 3'd3, ev(2));
        pulse_ack();
        expect_out("R2 ack clears", 1'b0, 3'd0, 24'h0);
        step();
        step();
        expect_out("R2 held high raises no more", 1'b0, 3'd0, 24'h0);
    endtask

    task automatic t_glitch();
        ext_line[2] = 1'b0;
        step();
        expect_out("R3 dip alone no request", 1'b0, 3'd0, 24'h0);
        ext_line[2] = 1'b1;
        step();
        expect_out("R3 return high re-raises", 1'b1, 3'd3, ev(2));
        pulse_ack();
        ext_line = '0;
        step();
    endtask

    task automatic t_priority();
        ext_line = 4'b1010;
        step();
        expect_out("R6 lower index wins", 1'b1, 3'd2, ev(1));
        pulse_ack();
        expect_out("R6 next source vector", 1'b1, 3'd4, ev(3));
        pulse_ack();
        expect_out("R6 drained", 1'b0, 3'd0, 24'h0);
        ext_line = '0;
        step();
    endtask

    task automatic t_masking();
        mask = 4'b1110;
        ext_line[0] = 1'b1;
        step();
        expect_out("R5 masked bit hidden", 1'b0, 3'd0, 24'h0);
        mask = 4'b1111;
        glob_en = 1'b0;
        step();
        expect_out("R5 global disable hides", 1'b0, 3'd0, 24'h0);
        glob_en = 1'b1;
        step();
        expect_out("R5 pending kept while masked", 1'b1, 3'd1, ev(0));
        pulse_ack();
        ext_line = '0;
        step();
    endtask

    task automatic t_nmi();
        glob_en = 1'b0;
        mask = '0;
        wr_data = 4'b0001;
        mode_we = 1'b1;
        step();
        mode_we = 1'b0;
        nmi_line = 1'b1;
        step();
        expect_out("R4 nmi ignores enables", 1'b1, 3'd0, NMI_V);
        glob_en = 1'b1;
        mask = 4'b1111;
        step();
        expect_out("R4 nmi beats pending ext", 1'b1, 3'd0, NMI_V);
        pulse_ack();
        expect_out("R8 mode write had set bit0", 1'b1, 3'd1, ev(0));
        pulse_ack();
        expect_out("R4 nmi held high once", 1'b0, 3'd0, 24'h0);
        nmi_line = 1'b0;
        step();
    endtask

    task automatic t_ack_race();
        ext_line[1] = 1'b1;
        step();
        ext_line[1] = 1'b0;
        step();
        expect_out("R7 pending kept after line low", 1'b1, 3'd2, ev(1));
        ext_line[1] = 1'b1;
        ack = 1'b1;
        step();
        ack = 1'b0;
        expect_out("R7 same-cycle edge re-sets", 1'b1, 3'd2, ev(1));
        pulse_ack();
        expect_out("R7 ack clears", 1'b0, 3'd0, 24'h0);
        ext_line = '0;
        step();
    endtask

    task automatic t_writes();
        wr_data = 4'b1010;
        mode_we = 1'b1;
        step();
        mode_we = 1'b0;
        expect_out("R8 mode write sets", 1'b1, 3'd2, ev(1));
        wr_data = 4'b0010;
        clr_we = 1'b1;
        step();
        clr_we = 1'b0;
        expect_out("R8 clear write clears", 1'b1, 3'd4, ev(3));
        wr_data = 4'b1001;
        mode_we = 1'b1;
        clr_we = 1'b1;
        step();
        mode_we = 1'b0;
        clr_we = 1'b0;
        expect_out("R9 clear wins over set", 1'b0, 3'd0, 24'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        step();
        t_reset();
        glob_en = 1'b1;
        mask = 4'b1111;
        t_phase_gate();
        t_single_edge();
        t_glitch();
        t_priority();
        t_masking();
        t_nmi();
        t_ack_race();
        t_writes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule